// File: doc/BRIEF.md
# Serial Port Transmit/Receive Word Queue

This block is the word-level layer of a synchronous serial port, placed between a 32-bit processor data register and the bit shifter. Software writes transmit words right-aligned; the block trims each word to the active frame size, moves it to the top of the 32-bit lane and queues it until the shifter takes it. Words the shifter assembles are masked to the receive size and queued right-justified until software reads them.

Both queues report their fill level, a full/empty indication and a comparison against a programmable trigger level. A receive idle timer raises a flag when words have sat in the receive queue with no push and no pop for a programmed number of cycles. Frame format, data size and the command size used in the three-wire command format are static configuration inputs. Dropping the port enable empties both queues in one cycle.

Top module: `serq_datapath`

## Requirements
- R1: In the standard formats (`fmt` 2'b00 or 2'b01) the transmit size is N = `dsize`+1 bits (`dsize` below 3 counts as 4 bits); `tx_word[31:32-N]` carries `wr_data[N-1:0]` and all lower bits are zero.
- R2: In the command format (`fmt` 2'b10) the transmit size is 8 bits when `uw_cmd16` is 0 and 16 bits when it is 1, regardless of `dsize`; the rest of the write word is ignored.
- R3: A received word is stored as `rx_shift[N-1:0]` with N = `dsize`+1 in every format, and bits N and above read back as zero on `rd_data`.
- R4: A write while the transmit queue holds 16 words is dropped: the level stays 16 and the queued words and their order are unchanged.
- R5: Each queue holds 16 words in arrival order; a push and a pop in the same cycle leave the level unchanged, and levels update on the clock edge after the request.
- R6: `tx_not_full` is 1 exactly when `tx_level` is below 16; `rx_not_empty` is 1 exactly when `rx_level` is non-zero.
- R7: `tx_low` is 1 when `tx_level` <= `tx_thresh`; `rx_high` is 1 when `rx_level` > `rx_thresh`.
- R8: With the port enabled and `tmo_limit` = L > 0, `rx_timeout` rises after L consecutive clock edges with a non-empty receive queue and no receive push or pop, and stays low before that.
- R9: Any accepted receive push or pop restarts the idle count and clears `rx_timeout`; `tmo_limit` = 0 keeps `rx_timeout` low.
- R10: `rd_en` while `port_en` is 0 does not pop the receive queue; `rd_data` is then don't-care.
- R11: On the first cycle `port_en` is low after being high, both queues are emptied and `rx_timeout` clears at that clock edge; writes and pushes in that cycle are discarded.
- R12: A receive push while the receive queue holds 16 words is dropped and the level stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; its falling edge flushes |
| fmt | input | 2 | Frame format: 00, 01 standard, 10 command format |
| dsize | input | 5 | Data size minus one |
| uw_cmd16 | input | 1 | Command format transmit size: 0 = 8 bits, 1 = 16 bits |
| tx_thresh | input | 5 | Transmit trigger level |
| rx_thresh | input | 5 | Receive trigger level |
| tmo_limit | input | 16 | Receive idle limit in cycles, 0 disables |
| wr_en | input | 1 | Software write to the data register |
| wr_data | input | 32 | Right-aligned transmit word |
| rd_en | input | 1 | Software read of the data register |
| rd_data | output | 32 | Head of the receive queue, right-justified |
| tx_pop | input | 1 | Shifter takes the head transmit word |
| tx_word | output | 32 | Head transmit word, left-justified |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_shift | input | 32 | Raw received word from the shifter |
| tx_level | output | 5 | Transmit queue fill level |
| rx_level | output | 5 | Receive queue fill level |
| tx_not_full | output | 1 | Transmit queue can take a word |
| rx_not_empty | output | 1 | Receive queue holds a word |
| tx_low | output | 1 | Transmit level at or below trigger |
| rx_high | output | 1 | Receive level above trigger |
| rx_timeout | output | 1 | Receive idle timeout flag |

## Verification
A corrupted pointer or level counter shows up on the next edge as a wrong `tx_level`/`rx_level`, and on the following reads as words returned out of order or a dropped word that reappears, so the bench fills each queue past capacity and drains it in order. An alignment fault shows on `tx_word` or `rd_data` one edge after the word is queued, which the vector table covers across sizes and formats. An idle counter that starts or restarts on the wrong edge moves the rise of `rx_timeout` by one or more cycles, so the bench samples the flag on the cycle before and the cycle of its expected rise, with and without an intervening push.

// File: rtl/serq_pkg.sv
// Shared definitions for the serial port word queue.
// Assumes a 32-bit data register and sizes from 4 to 32 bits.
package serq_pkg;

    localparam int WORD_W = 32;
    localparam int SIZE_W = 6;

    typedef enum logic [1:0] {
        FMT_STD_A = 2'b00,
        FMT_STD_B = 2'b01,
        FMT_CMD   = 2'b10,
        FMT_RSVD  = 2'b11
    } frame_fmt_e;

    // Word size in bits from a size-minus-one field, clamped to at least 4.
    function automatic logic [SIZE_W-1:0] size_from_field(input logic [4:0] field);
        if (field < 5'd3) begin
            return SIZE_W'(4);
        end
        return SIZE_W'(field) + SIZE_W'(1);
    endfunction

endpackage

// File: rtl/serq_align.sv
// Word alignment between the data register and the shifter.
// Transmit: trims to the frame size and left-justifies.
// Receive: masks to the receive size, keeping the word right-justified.
// Assumes configuration inputs are static while words are in flight.
module serq_align
    import serq_pkg::*;
#(
    parameter int WORD_W_P = WORD_W
) (
    input  logic [1:0]          fmt,
    input  logic [4:0]          dsize,
    input  logic                uw_cmd16,
    input  logic [WORD_W_P-1:0] tx_in,
    input  logic [WORD_W_P-1:0] rx_in,
    output logic [WORD_W_P-1:0] tx_out,
    output logic [WORD_W_P-1:0] rx_out
);

    logic [SIZE_W-1:0]   tx_n;
    logic [SIZE_W-1:0]   rx_n;
    logic [WORD_W_P-1:0] tx_mask;
    logic [WORD_W_P-1:0] rx_mask;
    logic [SIZE_W-1:0]   tx_shift;

    // Pick the transmit size from the format and the receive size from dsize.
    always_comb begin
        rx_n = size_from_field(dsize);
        if (frame_fmt_e'(fmt) == FMT_CMD) begin
            tx_n = uw_cmd16 ? SIZE_W'(16) : SIZE_W'(8);
        end else begin
            tx_n = rx_n;
        end
        tx_shift = SIZE_W'(WORD_W_P) - tx_n;
    end

    // Build the keep masks bit by bit.
    for (genvar i = 0; i < WORD_W_P; i++) begin : g_mask
        assign tx_mask[i] = (SIZE_W'(i) < tx_n);
        assign rx_mask[i] = (SIZE_W'(i) < rx_n);
    end

    // Apply masks and move transmit data to the top of the lane.
    always_comb begin
        tx_out = (tx_in & tx_mask) << tx_shift;
        rx_out = rx_in & rx_mask;
    end

endmodule

// File: rtl/serq_fifo.sv
// Synchronous word queue with fill level.
// Push when full and pop when empty are ignored; flush empties it.
// Assumes DEPTH is a power of two.
module serq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LVL_W-1:0] level,
    output logic             push_ok,
    output logic             pop_ok
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Accept requests only where capacity or data exists, never during flush.
    always_comb begin
        push_ok = push && !flush && (level != LVL_W'(DEPTH));
        pop_ok  = pop && !flush && (level != '0);
        dout    = mem[rd_ptr];
    end

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    // Track pointers and level; simultaneous push and pop cancel in the level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            if (push_ok && !pop_ok) begin
                level <= level + LVL_W'(1);
            end else if (pop_ok && !push_ok) begin
                level <= level - LVL_W'(1);
            end
        end
    end

endmodule

// File: rtl/serq_idle_timer.sv
// Receive idle timer: counts edges with pending data and no activity.
// Assumes activity already reflects accepted pushes and pops only.
module serq_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enable,
    input  logic             nonempty,
    input  logic             activity,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;
    logic             run;

    // Counting is allowed only with data waiting and a non-zero limit.
    always_comb begin
        run     = enable && nonempty && (limit != '0);
        expired = run && (cnt >= limit);
    end

    // Restart on activity or idle conditions, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || activity || !run) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/serq_datapath.sv
// Serial port word queue top: transmit and receive queues, alignment,
// trigger comparisons and receive idle timeout.
// Assumes configuration is static while data is queued; the falling
// edge of port_en flushes both queues.
module serq_datapath
    import serq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [1:0]        fmt,
    input  logic [4:0]        dsize,
    input  logic              uw_cmd16,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_word,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_shift,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              tx_not_full,
    output logic              rx_not_empty,
    output logic              tx_low,
    output logic              rx_high,
    output logic              rx_timeout
);

    logic              en_q;
    logic              flush;
    logic [WORD_W-1:0] tx_aligned;
    logic [WORD_W-1:0] rx_masked;
    logic              tx_push_ok;
    logic              tx_pop_ok;
    logic              rx_push_ok;
    logic              rx_pop_ok;

    // Remember the enable to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= port_en;
        end
    end

    // Flush for one cycle when the enable drops.
    always_comb flush = en_q && !port_en;

    serq_align #(.WORD_W_P(WORD_W)) u_align (
        .fmt      (fmt),
        .dsize    (dsize),
        .uw_cmd16 (uw_cmd16),
        .tx_in    (wr_data),
        .rx_in    (rx_shift),
        .tx_out   (tx_aligned),
        .rx_out   (rx_masked)
    );

    serq_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (wr_en),
        .din     (tx_aligned),
        .pop     (tx_pop),
        .dout    (tx_word),
        .level   (tx_level),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok)
    );

    serq_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (rx_push),
        .din     (rx_masked),
        .pop     (rd_en && port_en),
        .dout    (rd_data),
        .level   (rx_level),
        .push_ok (rx_push_ok),
        .pop_ok  (rx_pop_ok)
    );

    serq_idle_timer #(.CNT_W(TMO_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .enable   (port_en),
        .nonempty (rx_level != '0),
        .activity (rx_push_ok || rx_pop_ok),
        .limit    (tmo_limit),
        .expired  (rx_timeout)
    );

    // Status flags and trigger comparisons from the levels.
    always_comb begin
        tx_not_full  = (tx_level != LVL_W'(DEPTH));
        rx_not_empty = (rx_level != '0);
        tx_low       = (tx_level <= tx_thresh);
        rx_high      = (rx_level > rx_thresh);
    end

endmodule

// File: rtl/serq_datapath_chk.sv
// Assertion checker for serq_datapath, attached by bind.
module serq_datapath_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             flush,
    input logic [4:0]       dsize,
    input logic             wr_en,
    input logic             tx_pop,
    input logic             rx_push,
    input logic             rd_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [31:0]      tx_word,
    input logic [31:0]      rd_data,
    input logic             rx_timeout
);

    // R4: write to a full transmit queue changes neither level nor head
    p_tx_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && tx_level == LVL_W'(DEPTH) && wr_en && !tx_pop)
        |=> (tx_level == LVL_W'(DEPTH) && $stable(tx_word)));

    // R5: levels never exceed the depth
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    // R5: push with pop on a partly filled queue keeps the level
    p_pushpop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && tx_level != '0 && tx_level != LVL_W'(DEPTH) && wr_en && tx_pop)
        |=> (tx_level == $past(tx_level)));

    // R12: receive push into a full queue is dropped
    p_rx_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rx_level == LVL_W'(DEPTH) && rx_push && !(rd_en && port_en))
        |=> (rx_level == LVL_W'(DEPTH)));

    // R10: read while disabled does not pop
    p_rd_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !flush && rd_en && !rx_push)
        |=> (rx_level == $past(rx_level)));

    // R11: falling enable empties both queues and clears the timeout
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0 && !rx_timeout));

    // R9: accepted receive activity restarts the idle count
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_push && rx_level != LVL_W'(DEPTH)) || (rd_en && port_en && rx_level != '0))
        |=> !rx_timeout);

    // R3: queued receive data has zero bits above the receive size
    p_rx_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rx_level != '0 && dsize >= 5'd3 && dsize < 5'd31)
        |-> ((rd_data >> (6'(dsize) + 6'd1)) == 32'd0));

endmodule

bind serq_datapath serq_datapath_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .flush      (flush),
    .dsize      (dsize),
    .wr_en      (wr_en),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rd_en      (rd_en),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_word    (tx_word),
    .rd_data    (rd_data),
    .rx_timeout (rx_timeout)
);

// File: tb/sim_serq_datapath.sv
// Bench for serq_datapath: vector table for alignment, then directed tests.
module sim_serq_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [4:0]  dsize = 5'd31;
    logic        uw_cmd16 = 1'b0;
    logic [4:0]  tx_thresh = 5'd4;
    logic [4:0]  rx_thresh = 5'd2;
    logic [15:0] tmo_limit = 16'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_shift = '0;
    logic [4:0]  tx_level;
    logic [4:0]  rx_level;
    logic        tx_not_full;
    logic        rx_not_empty;
    logic        tx_low;
    logic        rx_high;
    logic        rx_timeout;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    serq_datapath u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .fmt(fmt), .dsize(dsize),
        .uw_cmd16(uw_cmd16), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tmo_limit(tmo_limit), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tx_pop(tx_pop), .tx_word(tx_word), .rx_push(rx_push),
        .rx_shift(rx_shift), .tx_level(tx_level), .rx_level(rx_level),
        .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty), .tx_low(tx_low),
        .rx_high(rx_high), .rx_timeout(rx_timeout)
    );

    // fmt, dsize, cmd16, write word, expected tx_word, raw rx word, expected rd_data
    localparam logic [135:0] VEC [7] = '{
        {2'd0, 5'd7,  1'b0, 32'hFFFF_FFA5, 32'hA500_0000, 32'hFFFF_FF3C, 32'h0000_003C},
        {2'd0, 5'd15, 1'b0, 32'h1234_BEEF, 32'hBEEF_0000, 32'hAAAA_5555, 32'h0000_5555},
        {2'd0, 5'd31, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h8000_0001, 32'h8000_0001},
        {2'd0, 5'd3,  1'b0, 32'h0000_00FB, 32'hB000_0000, 32'hFFFF_FFF6, 32'h0000_0006},
        {2'd2, 5'd31, 1'b0, 32'h1234_5678, 32'h7800_0000, 32'hCAFE_F00D, 32'hCAFE_F00D},
        {2'd2, 5'd3,  1'b1, 32'h1234_5678, 32'h5678_0000, 32'h1234_567F, 32'h0000_000F},
        {2'd1, 5'd11, 1'b0, 32'hFFFF_FABC, 32'hABC0_0000, 32'h0001_2345, 32'h0000_0345}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic tx_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic rx_write(input logic [31:0] d);
        rx_push = 1'b1; rx_shift = d; tick(); rx_push = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state
        chk("R5 reset tx_level", 32'(tx_level), 32'd0);
        chk("R5 reset rx_level", 32'(rx_level), 32'd0);
        chk("R6 reset tx_not_full", 32'(tx_not_full), 32'd1);
        chk("R6 reset rx_not_empty", 32'(rx_not_empty), 32'd0);
        chk("R7 reset tx_low", 32'(tx_low), 32'd1);
        chk("R8 reset rx_timeout", 32'(rx_timeout), 32'd0);

        port_en = 1'b1;
        tick();
        // Vector table: alignment in every format and size
        foreach (VEC[i]) begin
            fmt = VEC[i][135:134]; dsize = VEC[i][133:129]; uw_cmd16 = VEC[i][128];
            wr_en = 1'b1; wr_data = VEC[i][127:96];
            rx_push = 1'b1; rx_shift = VEC[i][63:32];
            tick();
            wr_en = 1'b0; rx_push = 1'b0;
            chk(VEC[i][135:134] == 2'd2 ? "R2 tx_word" : "R1 tx_word", tx_word, VEC[i][95:64]);
            chk("R3 rd_data", rd_data, VEC[i][31:0]);
            tx_pop = 1'b1; rd_en = 1'b1;
            tick();
            tx_pop = 1'b0; rd_en = 1'b0;
        end
        fmt = 2'b00; dsize = 5'd31; uw_cmd16 = 1'b0;

        // R4/R5/R6: fill the transmit queue, overfill, drain in order
        for (int i = 0; i < 16; i++) tx_write(32'h100 + 32'(i));
        chk("R5 tx full level", 32'(tx_level), 32'd16);
        chk("R6 tx_not_full at 16", 32'(tx_not_full), 32'd0);
        tx_write(32'hBAD0_BAD0);
        chk("R4 level after dropped write", 32'(tx_level), 32'd16);
        for (int i = 0; i < 16; i++) begin
            chk("R4 order after dropped write", tx_word, 32'h100 + 32'(i));
            tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        end
        chk("R5 tx drained", 32'(tx_level), 32'd0);

        // R5: simultaneous push and pop
        tx_write(32'h11); tx_write(32'h22);
        wr_en = 1'b1; wr_data = 32'h33; tx_pop = 1'b1; tick();
        wr_en = 1'b0; tx_pop = 1'b0;
        chk("R5 push+pop level", 32'(tx_level), 32'd2);
        chk("R5 push+pop head", tx_word, 32'h22);
        tx_pop = 1'b1; tick(); tick(); tx_pop = 1'b0;

        // R7: trigger comparisons
        for (int i = 0; i < 4; i++) tx_write(32'(i));
        chk("R7 tx_low at level 4", 32'(tx_low), 32'd1);
        tx_write(32'h5);
        chk("R7 tx_low at level 5", 32'(tx_low), 32'd0);
        tx_pop = 1'b1; repeat (5) tick(); tx_pop = 1'b0;
        rx_write(32'h1); rx_write(32'h2);
        chk("R7 rx_high at level 2", 32'(rx_high), 32'd0);
        rx_write(32'h3);
        chk("R7 rx_high at level 3", 32'(rx_high), 32'd1);
        chk("R6 rx_not_empty", 32'(rx_not_empty), 32'd1);

        // R12: receive overflow
        for (int i = 3; i < 17; i++) rx_write(32'h40 + 32'(i));
        chk("R12 rx level after overflow", 32'(rx_level), 32'd16);
        chk("R5 rx order head", rd_data, 32'h1);
        rd_en = 1'b1; repeat (16) tick(); rd_en = 1'b0;
        chk("R5 rx drained", 32'(rx_level), 32'd0);

        // R8: timeout rises after exactly L idle edges
        tmo_limit = 16'd5;
        rx_write(32'hA1);
        repeat (4) tick();
        chk("R8 no timeout after 4 idle", 32'(rx_timeout), 32'd0);
        tick();
        chk("R8 timeout after 5 idle", 32'(rx_timeout), 32'd1);

        // R9: a push restarts the count
        rx_write(32'hA2);
        chk("R9 cleared by push", 32'(rx_timeout), 32'd0);
        repeat (3) tick();
        rx_write(32'hA3);
        repeat (4) tick();
        chk("R9 restarted count", 32'(rx_timeout), 32'd0);
        tick();
        chk("R9 timeout after restart", 32'(rx_timeout), 32'd1);

        // R11: dropping the enable flushes everything
        tx_write(32'h77);
        port_en = 1'b0; tick();
        chk("R11 tx flushed", 32'(tx_level), 32'd0);
        chk("R11 rx flushed", 32'(rx_level), 32'd0);
        chk("R11 timeout cleared", 32'(rx_timeout), 32'd0);

        // R10: read while disabled leaves the word queued
        rx_write(32'h55);
        rd_en = 1'b1; repeat (3) tick(); rd_en = 1'b0;
        chk("R10 level after disabled reads", 32'(rx_level), 32'd1);
        port_en = 1'b1; tick();
        chk("R10 word kept", rd_data, 32'h55);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R10 popped once enabled", 32'(rx_level), 32'd0);

        // R9: zero limit disables the timeout
        tmo_limit = 16'd0;
        rx_write(32'h66);
        repeat (20) tick();
        chk("R9 zero limit no timeout", 32'(rx_timeout), 32'd0);
        rd_en = 1'b1; tick(); rd_en = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule